// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral with a small register file on a 16-bit register bus. A 10-bit down-counter starts from a programmable start value. It steps down once for each pulse on the tick input, as long as it is neither halted nor stalled. The tick input comes from a prescaler outside the block; at the nominal rate one tick lasts about 0.6 s, so a timeout of S seconds corresponds to roughly S*10/6 ticks.

A tick that arrives while the counter is already at zero is an expiry. The first expiry sets a sticky first-timeout flag, can raise a one-cycle interrupt pulse, and reloads the counter. If the counter expires again while that flag is still set, the block records the second timeout and the boot status. It asks for a system reset with a one-cycle pulse unless the no-reboot bit blocks it, and it then stalls at zero until software reloads it. Software services the watchdog by writing to the reload offset and by clearing the flags with write-one-to-clear.

The bus has no back-pressure. `bus_ready_o` is tied high, so a request is taken in every cycle that `bus_valid_i` is high. A write takes effect at the next clock edge. Read data is combinational and valid in the same cycle as the request. Register offsets: 0x00 reload/count, 0x04 status A, 0x06 status B, 0x08 control, 0x0C interrupt enable, 0x12 start value.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the control word reads 0x0800 (halted), the count reads 0x3FF, the start-value register reads 0x03FF, and every status bit and the interrupt enable read 0.
- R2: While the counter runs (control bit 11 clear and not stalled), each tick lowers the count by one. While bit 11 is set, ticks leave the count unchanged. Offset 0x00 returns the live count in bits 9:0, and its upper bits read 0.
- R3: Any write to offset 0x00 loads the count from the start field at the next edge and clears a stall. It takes precedence over a tick or an expiry in the same cycle.
- R4: The start field is bits 9:0 of offset 0x12. A write whose bits 9:0 are below 4 is ignored entirely. Any other write stores all 16 bits, and they read back unchanged.
- R5: A tick while the count is 0, while running and while status A bit 3 is clear, is a first expiry. It sets status A bit 3 and reloads the count from the start field.
- R6: `irq_o` is high for exactly the one cycle after a first expiry, and only if bit 13 of offset 0x0C was set.
- R7: A tick while the count is 0, while running and while status A bit 3 is set, is a second expiry. It sets status B bit 1 (second timeout) and bit 2 (boot), and leaves the count at 0 with ticks ignored until a reload write.
- R8: `rst_req_o` is high for exactly the one cycle after a second expiry, unless control bit 0 (no-reboot) was set.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an expiry sets a bit in the same cycle that software clears it, the bit ends up set.
- R10: Control offset 0x08 stores and returns all 16 bits as written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle prescaler tick |
| bus_valid_i | input | 1 | Register request valid |
| bus_ready_o | output | 1 | Always 1; no back-pressure |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, same cycle; 0 when no read is requested |
| irq_o | output | 1 | Interrupt pulse on first expiry |
| rst_req_o | output | 1 | Reset request pulse on second expiry |

## Verification
The assertions assume the following about the inputs:
- `tick_i` may arrive in any cycle, including back to back.
- Bus requests are whole 16-bit words.
- A reload write does not come back within four ticks of a reset pulse in a way that could make the reset request last longer than one cycle. This holds because the start field never drops below 4.

The stimulus stays within these limits. It keeps every start value in the range 4 to 12, so that expiries come often. It sets the halt bit only in a small share of control writes, and it draws every address from the mapped offsets plus one unmapped offset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 5;
  localparam int CNT_W    = 10;
  localparam int INIT_MIN = 4;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STSA   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STSB   = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_IRQEN  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_START  = 5'h12;

  localparam int BIT_FIRST    = 3;
  localparam int BIT_SECOND   = 1;
  localparam int BIT_BOOT     = 2;
  localparam int BIT_HALT     = 11;
  localparam int BIT_NOREBOOT = 0;
  localparam int BIT_IRQEN    = 13;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int CW   = CNT_W,
  parameter int IMIN = INIT_MIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          set_first,
  input  logic          set_second,
  input  logic [CW-1:0] count,
  output logic [DW-1:0] rdata,
  output logic          reload_pulse,
  output logic          halt,
  output logic          noreboot,
  output logic          irq_en,
  output logic [CW-1:0] start_val,
  output logic          sts_first,
  output logic          sts_second,
  output logic          sts_boot
);
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] start_q;
  logic          irq_en_q;

  logic wr_stsa, wr_stsb, wr_ctrl, wr_irqen, wr_start_ok;

  assign reload_pulse = wr_en && (addr == OFS_RELOAD);
  assign wr_stsa      = wr_en && (addr == OFS_STSA);
  assign wr_stsb      = wr_en && (addr == OFS_STSB);
  assign wr_ctrl      = wr_en && (addr == OFS_CTRL);
  assign wr_irqen     = wr_en && (addr == OFS_IRQEN);
  assign wr_start_ok  = wr_en && (addr == OFS_START) && (wdata[CW-1:0] >= CW'(IMIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q             <= '0;
      ctrl_q[BIT_HALT]   <= 1'b1;
      start_q            <= '0;
      start_q[CW-1:0]    <= '1;
      irq_en_q           <= 1'b0;
      sts_first          <= 1'b0;
      sts_second         <= 1'b0;
      sts_boot           <= 1'b0;
    end else begin
      if (wr_ctrl)     ctrl_q   <= wdata;
      if (wr_start_ok) start_q  <= wdata;
      if (wr_irqen)    irq_en_q <= wdata[BIT_IRQEN];
      sts_first  <= set_first  | (sts_first  & ~(wr_stsa & wdata[BIT_FIRST]));
      sts_second <= set_second | (sts_second & ~(wr_stsb & wdata[BIT_SECOND]));
      sts_boot   <= set_second | (sts_boot   & ~(wr_stsb & wdata[BIT_BOOT]));
    end
  end

  assign halt      = ctrl_q[BIT_HALT];
  assign noreboot  = ctrl_q[BIT_NOREBOOT];
  assign irq_en    = irq_en_q;
  assign start_val = start_q[CW-1:0];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_RELOAD: rdata[CW-1:0]       = count;
        OFS_STSA:   rdata[BIT_FIRST]    = sts_first;
        OFS_STSB: begin
          rdata[BIT_SECOND] = sts_second;
          rdata[BIT_BOOT]   = sts_boot;
        end
        OFS_CTRL:   rdata               = ctrl_q;
        OFS_IRQEN:  rdata[BIT_IRQEN]    = irq_en_q;
        OFS_START:  rdata               = start_q;
        default:    rdata               = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          halt,
  input  logic          reload,
  input  logic [CW-1:0] start_val,
  input  logic          sts_first,
  input  logic          irq_en,
  input  logic          noreboot,
  output logic [CW-1:0] count,
  output logic          exp_first,
  output logic          exp_second,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic stalled;
  logic run;
  logic hit_zero;

  assign run        = !halt && !stalled;
  assign hit_zero   = tick && run && (count == '0) && !reload;
  assign exp_first  = hit_zero && !sts_first;
  assign exp_second = hit_zero && sts_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '1;
      stalled   <= 1'b0;
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= exp_first && irq_en;
      rst_req_o <= exp_second && !noreboot;
      if (reload) begin
        count   <= start_val;
        stalled <= 1'b0;
      end else if (exp_first) begin
        count   <= start_val;
      end else if (exp_second) begin
        stalled <= 1'b1;
      end else if (tick && run) begin
        count   <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int AW   = ADDR_W,
  parameter int CW   = CNT_W,
  parameter int IMIN = INIT_MIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          bus_valid_i,
  output logic          bus_ready_o,
  input  logic          bus_write_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic          wr_en, rd_en;
  logic          reload_pulse, halt, noreboot, irq_en;
  logic [CW-1:0] start_val, count;
  logic          sts_first, sts_second, sts_boot;
  logic          exp_first, exp_second;

  assign bus_ready_o = 1'b1;
  assign wr_en = bus_valid_i && bus_write_i;
  assign rd_en = bus_valid_i && !bus_write_i;

  wdt_regs #(.DW(DW), .AW(AW), .CW(CW), .IMIN(IMIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(bus_addr_i), .wdata(bus_wdata_i),
    .set_first(exp_first), .set_second(exp_second), .count(count),
    .rdata(bus_rdata_o), .reload_pulse(reload_pulse), .halt(halt),
    .noreboot(noreboot), .irq_en(irq_en), .start_val(start_val),
    .sts_first(sts_first), .sts_second(sts_second), .sts_boot(sts_boot)
  );

  wdt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .halt(halt),
    .reload(reload_pulse), .start_val(start_val), .sts_first(sts_first),
    .irq_en(irq_en), .noreboot(noreboot), .count(count),
    .exp_first(exp_first), .exp_second(exp_second),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CW   = 10,
  parameter int IMIN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_o,
  input logic          rst_req_o,
  input logic          halt,
  input logic          reload_pulse,
  input logic          noreboot,
  input logic          irq_en,
  input logic          sts_first,
  input logic          sts_boot,
  input logic [CW-1:0] count,
  input logic [CW-1:0] start_val
);
  assert_halt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_pulse) |=> $stable(count));

  assert_start_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_val >= CW'(IMIN));

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(irq_en) && sts_first));

  assert_reset_sets_boot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> sts_boot);

  assert_reset_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  assert_reset_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !$past(noreboot));

  assert_stage_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && rst_req_o));
endmodule

bind wdt_two_stage wdt_checker #(.CW(CW), .IMIN(IMIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .halt(halt), .reload_pulse(reload_pulse), .noreboot(noreboot),
  .irq_en(irq_en), .sts_first(sts_first), .sts_boot(sts_boot),
  .count(count), .start_val(start_val)
);

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic        write = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, rreq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [9:0]  m_cnt;
  logic [15:0] m_ctrl, m_start;
  logic        m_irqen, m_first, m_second, m_boot, m_stall, m_irq, m_rst;

  always #2 clk = ~clk;

  wdt_two_stage dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_valid_i(valid),
    .bus_ready_o(ready), .bus_write_i(write), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .rst_req_o(rreq)
  );

  function automatic logic [15:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return {6'b0, m_cnt};
      5'h04: return {12'b0, m_first, 3'b0};
      5'h06: return {13'b0, m_boot, m_second, 1'b0};
      5'h08: return m_ctrl;
      5'h0C: return {2'b0, m_irqen, 13'b0};
      5'h12: return m_start;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [4:0] a);
    case (a)
      5'h00: return "R2";
      5'h04: return "R5";
      5'h06: return "R7";
      5'h0C: return "R6";
      5'h12: return "R4";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 10'h3FF; m_ctrl = 16'h0800; m_start = 16'h03FF;
    m_irqen = 0; m_first = 0; m_second = 0; m_boot = 0; m_stall = 0;
    m_irq = 0; m_rst = 0;
  endtask

  task automatic model_step(input logic v, input logic w, input logic [4:0] a,
                            input logic [15:0] d, input logic t);
    logic wr, rl, run, hz, e1, e2;
    wr  = v && w;
    rl  = wr && (a == 5'h00);
    run = !m_ctrl[11] && !m_stall;
    hz  = t && run && (m_cnt == 0) && !rl;
    e1  = hz && !m_first;
    e2  = hz && m_first;
    m_irq = e1 && m_irqen;
    m_rst = e2 && !m_ctrl[0];
    if (rl) begin m_cnt = m_start[9:0]; m_stall = 0; end
    else if (e1) m_cnt = m_start[9:0];
    else if (e2) m_stall = 1;
    else if (t && run) m_cnt = m_cnt - 1'b1;
    m_first  = e1 | (m_first  & ~(wr && a == 5'h04 && d[3]));
    m_second = e2 | (m_second & ~(wr && a == 5'h06 && d[1]));
    m_boot   = e2 | (m_boot   & ~(wr && a == 5'h06 && d[2]));
    if (wr && a == 5'h08) m_ctrl = d;
    if (wr && a == 5'h0C) m_irqen = d[13];
    if (wr && a == 5'h12 && d[9:0] >= 10'd4) m_start = d;
  endtask

  // one clock cycle: drive at negedge, check read data, step model, check pulses
  task automatic cyc(input logic v, input logic w, input logic [4:0] a,
                     input logic [15:0] d, input logic t, input string tag);
    @(negedge clk);
    valid = v; write = w; addr = a; wdata = d; tick = t;
    #1;
    if (v && !w) check((tag == "") ? addr_tag(a) : tag, rdata, m_read(a));
    @(posedge clk);
    model_step(v, w, a, d, t);
    #1;
    if (irq || m_irq) check("R6", {15'b0, irq}, {15'b0, m_irq});
    if (rreq || m_rst) check("R8", {15'b0, rreq}, {15'b0, m_rst});
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    cyc(1, 0, a, 16'h0, 0, tag);
  endtask
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    cyc(1, 1, a, d, 0, "");
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 5'h0, 16'h0, 1, "");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] alist [7];
    alist = '{5'h00, 5'h04, 5'h06, 5'h08, 5'h0C, 5'h12, 5'h02};
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(5'h00, "R1"); rd(5'h04, "R1"); rd(5'h06, "R1");
    rd(5'h08, "R1"); rd(5'h0C, "R1"); rd(5'h12, "R1");
    check("R1", {15'b0, ready}, 16'h1);
    // R4 illegal start values ignored, legal keeps upper bits
    wr(5'h12, 16'hFC02); rd(5'h12, "R4");
    wr(5'h12, 16'h0003); rd(5'h12, "R4");
    wr(5'h12, 16'hFC05); rd(5'h12, "R4");
    // R2 halted: ticks ignored
    ticks(5); rd(5'h00, "R2");
    // R3 reload
    wr(5'h00, 16'h0); rd(5'h00, "R3");
    wr(5'h08, 16'h0000); rd(5'h08, "R10");
    wr(5'h0C, 16'h2000);
    ticks(3); rd(5'h00, "R2");
    // R5/R6 first expiry, R7/R8 second
    ticks(3); rd(5'h04, "R5"); rd(5'h00, "R5");
    ticks(6); rd(5'h06, "R7");
    ticks(4); rd(5'h00, "R7");
    // R9 W1C
    wr(5'h06, 16'h0002); rd(5'h06, "R9");
    wr(5'h06, 16'h0004); wr(5'h04, 16'h0008); rd(5'h04, "R9"); rd(5'h06, "R9");
    // R3 reload clears stall, R8 no-reboot blocks
    wr(5'h08, 16'h0001); wr(5'h00, 16'h0); rd(5'h00, "R3");
    ticks(14); rd(5'h06, "R8"); rd(5'h00, "R7");
    // R3 reload beats a tick in the same cycle
    cyc(1, 1, 5'h00, 16'h0, 1, ""); rd(5'h00, "R3");
    rd(5'h02, "R10");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [15:0] d;
      logic [4:0]  a;
      r = $urandom_range(0, 99);
      d = 16'($urandom);
      a = alist[$urandom_range(0, 6)];
      if (r < 40) cyc(0, 0, 5'h0, 16'h0, 1'($urandom_range(0, 1)), "");
      else if (r < 70) cyc(1, 0, a, 16'h0, 1'($urandom_range(0, 1)), "");
      else if (r < 75) cyc(1, 1, 5'h12,
                           {d[15:10], 10'($urandom_range(0, 12))}, 1'($urandom_range(0, 1)), "");
      else if (r < 80) cyc(1, 1, 5'h08,
                           {4'h0, ($urandom_range(0, 9) == 0), 10'h0, d[0]}, 1'($urandom_range(0, 1)), "");
      else if (r < 85) cyc(1, 1, 5'h00, d, 1'($urandom_range(0, 1)), "");
      else if (r < 92) cyc(1, 1, ($urandom_range(0, 1) != 0) ? 5'h04 : 5'h06, d,
                           1'($urandom_range(0, 1)), "R9");
      else cyc(1, 1, 5'h0C, d, 1'($urandom_range(0, 1)), "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule